// File: doc/BRIEF.md
# Glitch-Free CPU Clock Source Switch

This block produces the CPU clock from one of three sources: two configurable
dynamic paths fed from four fixed reference clocks, and a separate system PLL
clock. Each dynamic path picks one of the four references and then either
passes it straight through or divides it by a programmable integer. A single
32-bit control word, written and read in the `clk` domain, holds both path
settings, the dynamic path select and the final source select.

Software works in ping-pong fashion. It programs the path that is not driving
the output, then flips the dynamic select in the same write, or it changes the
final select. The block then hands the output over without glitches. The old
source is gated off on its own falling edge after a two-flop synchronizer in
its own domain. Only after that gating is seen back in the control domain is
the new source requested, and it is gated on through its own synchronizer. A
busy flag covers the whole handover, and writes made during it are dropped.

Top module: `cpuclk_switch`

## Requirements
- R1: After reset the control word reads 0x0400_0000 and `clk_out` runs at the `ref_clk[0]` period. That word means path 0 is live, both paths use reference 0 with the divider bypassed, the dynamic select is 0, the final select is 0 and the select-change enable is 1.
- R2: Each path has a divider count N (path 0 at bits 9:4, path 1 at bits 25:20) and a divider-use bit (path 0 at bit 2, path 1 at bit 18). When the bit is 1 and N>0, the path clock period is N+1 periods of its selected reference. When the bit is 0, or N=0, the selected reference passes through undivided.
- R3: The reference-select field of each path (path 0 at bits 1:0, path 1 at bits 17:16) chooses `ref_clk[value]` as that path's source.
- R4: The final-select bit 11 set to 1 drives `clk_out` from `pll_clk`. Set to 0, it drives `clk_out` from the path named by the dynamic-select bit 10.
- R5: Read bit 28 is the busy flag. It reads 1 from the clock edge that accepts a write changing the effective source (0 = path 0, 1 = path 1, 2 = PLL) until the new source is enabled. It then returns to 0.
- R6: A write presented while busy reads 1 is ignored, and the control word keeps its value.
- R7: While a dynamic path drives the output, writes leave that path's three fields unchanged.
- R8: Bit 26 of a write is stored, and it gates the dynamic-select update. When the written bit 26 is 0, bit 10 keeps its old value, while the other fields still take the write.
- R9: At most one source is enabled at any time, and `clk_out` never shows a pulse shorter than the shortest half-period among its sources.
- R10: A write that leaves the effective source unchanged is taken at once without raising busy, and the output period stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word with the busy flag at bit 28 |
| ref_clk | input | 4 | Four fixed reference clocks |
| pll_clk | input | 1 | System PLL clock |
| clk_out | output | 1 | Selected CPU clock |

## Verification
The output period is measured after each handover for several settings. These are an undivided reference, an even divide (by 4) and an odd divide (by 5), a divider-use bit of 1 with a count of 0, the highest reference index and the PLL. Together they separate reference selection from divider arithmetic and from the final select. Writes made in mid-handover, writes aimed at the live path and a flip with bit 26 cleared are checked by reading the word back and re-measuring the period, so a dropped or leaked field shows at the ports. A monitor runs across every handover and flags any `clk_out` pulse shorter than 1.5 ns.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_REF = 1 << SEL_W;
  localparam int DIV_W   = 6;
  localparam int NUM_SRC = 3;  // path 0, path 1, system PLL
  localparam int SRC_W   = 2;

  // bit positions in the control word
  localparam int P0_PRE  = 0;
  localparam int P0_POST = 2;
  localparam int P0_DIV  = 4;
  localparam int DYN_BIT = 10;
  localparam int FIN_BIT = 11;
  localparam int P1_PRE  = 16;
  localparam int P1_POST = 18;
  localparam int P1_DIV  = 20;
  localparam int DEN_BIT = 26;
  localparam int BSY_BIT = 28;

  typedef struct packed {
    logic [SEL_W-1:0] pre;
    logic             post;
    logic [DIV_W-1:0] div;
  } path_cfg_t;

  typedef struct packed {
    path_cfg_t p1;
    path_cfg_t p0;
    logic      dyn_en;
    logic      dyn;
    logic      fin;
  } ctrl_cfg_t;

  localparam ctrl_cfg_t RST_CFG = '{p1: '0, p0: '0, dyn_en: 1'b1, dyn: 1'b0, fin: 1'b0};

  function automatic path_cfg_t path_of(input logic [31:0] w, input int pre_at,
                                        input int post_at, input int div_at);
    path_cfg_t p;
    p.pre  = w[pre_at +: SEL_W];
    p.post = w[post_at];
    p.div  = w[div_at +: DIV_W];
    return p;
  endfunction

  function automatic logic [31:0] pack_word(input ctrl_cfg_t c, input logic busy);
    logic [31:0] w;
    w = '0;
    w[P0_PRE +: SEL_W] = c.p0.pre;
    w[P0_POST]         = c.p0.post;
    w[P0_DIV +: DIV_W] = c.p0.div;
    w[DYN_BIT]         = c.dyn;
    w[FIN_BIT]         = c.fin;
    w[P1_PRE +: SEL_W] = c.p1.pre;
    w[P1_POST]         = c.p1.post;
    w[P1_DIV +: DIV_W] = c.p1.div;
    w[DEN_BIT]         = c.dyn_en;
    w[BSY_BIT]         = busy;
    return w;
  endfunction

  // new control state after an accepted write; live = source driving the output
  function automatic ctrl_cfg_t merge_write(input ctrl_cfg_t old, input logic [31:0] w,
                                            input logic [SRC_W-1:0] live);
    ctrl_cfg_t n;
    n.p0     = (live == 2'd0) ? old.p0 : path_of(w, P0_PRE, P0_POST, P0_DIV);
    n.p1     = (live == 2'd1) ? old.p1 : path_of(w, P1_PRE, P1_POST, P1_DIV);
    n.dyn_en = w[DEN_BIT];
    n.dyn    = w[DEN_BIT] ? w[DYN_BIT] : old.dyn;
    n.fin    = w[FIN_BIT];
    return n;
  endfunction

  function automatic logic [SRC_W-1:0] target_of(input ctrl_cfg_t c);
    return c.fin ? 2'd2 : {1'b0, c.dyn};
  endfunction

  // number of source cycles the divided clock stays high in a period of n+1
  function automatic logic [DIV_W:0] high_len(input logic [DIV_W-1:0] n);
    return ({1'b0, n} + 1'b1) >> 1;
  endfunction
endpackage

// File: rtl/cpuclk_path.sv
module cpuclk_path
  import cpuclk_pkg::*;
(
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_clk,
  input  path_cfg_t          cfg,
  output logic               path_clk
);
  logic             src;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nx;
  logic             div_q;
  logic             use_div;

  assign src     = ref_clk[cfg.pre];
  assign use_div = cfg.post && (cfg.div != '0);

  always_comb cnt_nx = (cnt >= cfg.div) ? '0 : cnt + 1'b1;

  always_ff @(posedge src or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      div_q <= ({1'b0, cnt_nx} < high_len(cfg.div));
    end
  end

  assign path_clk = use_div ? div_q : src;
endmodule

// File: rtl/cpuclk_gate.sv
module cpuclk_gate #(
  parameter bit RST_ON = 1'b0
) (
  input  logic rst_n,
  input  logic src_clk,
  input  logic req,
  output logic en,
  output logic gclk
);
  logic s1, s2;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_ON;
      s2 <= RST_ON;
    end else begin
      s1 <= req;
      s2 <= s1;
    end
  end

  // enable changes only while the source is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en <= RST_ON;
    else        en <= s2;
  end

  assign gclk = src_clk & en;
endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
  import cpuclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [NUM_SRC-1:0] en_raw,
  output ctrl_cfg_t          cfg,
  output logic [NUM_SRC-1:0] req,
  output logic               busy,
  output logic [31:0]        rd_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_DROP, ST_RAISE} st_t;

  st_t                st;
  logic [SRC_W-1:0]   act;
  logic [SRC_W-1:0]   pend;
  logic [NUM_SRC-1:0] ack_s1, ack_s2;
  ctrl_cfg_t          cfg_nx;
  logic [SRC_W-1:0]   tgt_nx;
  logic               wr_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 3'b001;
      ack_s2 <= 3'b001;
    end else begin
      ack_s1 <= en_raw;
      ack_s2 <= ack_s1;
    end
  end

  assign wr_take = wr_en && (st == ST_IDLE);
  assign cfg_nx  = merge_write(cfg, wr_data, act);
  assign tgt_nx  = target_of(cfg_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= RST_CFG;
      req  <= 3'b001;
      act  <= 2'd0;
      pend <= 2'd0;
      st   <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (wr_take) begin
          cfg <= cfg_nx;
          if (tgt_nx != act) begin
            req[act] <= 1'b0;
            pend     <= tgt_nx;
            st       <= ST_DROP;
          end
        end
        ST_DROP: if (!ack_s2[act]) begin
          req[pend] <= 1'b1;
          st        <= ST_RAISE;
        end
        ST_RAISE: if (ack_s2[pend]) begin
          act <= pend;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign rd_data = pack_word(cfg, busy);

  assert_one_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_s2));
  assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));
  assert_idle_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ack_s2[act]);
  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(cfg));
  assert_live_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && act == 2'd0) |=> cfg.p0 == $past(cfg.p0));
endmodule

// File: rtl/cpuclk_switch.sv
module cpuclk_switch
  import cpuclk_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [31:0]  wr_data,
  output logic [31:0]  rd_data,
  input  logic [3:0]   ref_clk,
  input  logic         pll_clk,
  output logic         clk_out
);
  ctrl_cfg_t          cfg;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] gclk;
  logic [NUM_SRC-1:0] src_clk;
  logic               busy;

  cpuclk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_raw(en), .cfg(cfg), .req(req), .busy(busy), .rd_data(rd_data)
  );

  cpuclk_path u_path0 (.rst_n(rst_n), .ref_clk(ref_clk), .cfg(cfg.p0), .path_clk(src_clk[0]));
  cpuclk_path u_path1 (.rst_n(rst_n), .ref_clk(ref_clk), .cfg(cfg.p1), .path_clk(src_clk[1]));
  assign src_clk[2] = pll_clk;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    cpuclk_gate #(.RST_ON(g == 0)) u_gate (
      .rst_n(rst_n), .src_clk(src_clk[g]), .req(req[g]), .en(en[g]), .gclk(gclk[g])
    );
  end

  assign clk_out = |gclk;
endmodule

// File: tb/tb_cpuclk_switch.sv
`timescale 1ns/1ps
module tb_cpuclk_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  ref_clk = '0;
  logic        pll_clk = 1'b0;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  realtime last_edge = 0;

  cpuclk_switch dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ref_clk(ref_clk), .pll_clk(pll_clk), .clk_out(clk_out));

  always #2.5 clk = ~clk;
  always #5   ref_clk[0] = ~ref_clk[0];
  always #7   ref_clk[1] = ~ref_clk[1];
  always #11  ref_clk[2] = ~ref_clk[2];
  always #15  ref_clk[3] = ~ref_clk[3];
  always #2   pll_clk = ~pll_clk;

  // R9: no pulse on the output shorter than 1.5 ns
  always @(clk_out) begin
    if (mon_on && ($realtime - last_edge) < 1.5) glitches++;
    last_edge = $realtime;
  end

  task automatic chk32(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (rd_data[28]) @(negedge clk);
  endtask

  task automatic chk_period(input string rq, input real exp);
    realtime t1;
    real p;
    repeat (3) @(posedge clk_out);
    t1 = $realtime;
    @(posedge clk_out);
    p = $realtime - t1;
    checks++;
    if (p < exp - 0.01 || p > exp + 0.01) begin
      errors++;
      $display("FAIL %s period actual=%0.3f expected=%0.3f", rq, p, exp);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk32("R1", rd_data, 32'h0400_0000);
    chk_period("R1", 10.0);
  endtask

  // switch to path 1 (ref 2 divided by 4); a write during busy is dropped
  task automatic t_switch_path1();
    write_word(32'h0436_0400);
    chk32("R5", {31'b0, rd_data[28]}, 32'd1);
    write_word(32'h0000_0800);   // R6: presented while busy
    wait_idle();
    chk32("R6", rd_data, 32'h0436_0400);
    chk_period("R2", 88.0);
  endtask

  // live path fields are protected; same source leaves busy low
  task automatic t_live_lock();
    write_word(32'h0400_0400);
    chk32("R10", {31'b0, rd_data[28]}, 32'd0);
    chk32("R7", rd_data, 32'h0436_0400);
    chk_period("R7", 88.0);
  endtask

  // bit 26 clear: select flip not applied, idle path still written
  task automatic t_dyn_enable();
    write_word(32'h0036_0005);
    chk32("R8", {31'b0, rd_data[28]}, 32'd0);
    chk32("R8", rd_data, 32'h0036_0405);
    chk_period("R8", 88.0);
  endtask

  // back to path 0: ref 1, divider bit set with count 0 -> undivided
  task automatic t_switch_path0();
    write_word(32'h0436_0005);
    chk32("R5", {31'b0, rd_data[28]}, 32'd1);
    wait_idle();
    chk32("R3", rd_data, 32'h0436_0005);
    chk_period("R2", 14.0);
  endtask

  task automatic t_pll();
    write_word(32'h0436_0805);
    wait_idle();
    chk32("R4", rd_data, 32'h0436_0805);
    chk_period("R4", 4.0);
  endtask

  // from PLL to path 0 with odd divide by 5 of ref 0
  task automatic t_odd_divide();
    write_word(32'h0436_0044);
    wait_idle();
    chk32("R2", rd_data, 32'h0436_0044);
    chk_period("R2", 50.0);
  endtask

  // path 1 set to ref 3 undivided and selected
  task automatic t_ref3();
    write_word(32'h0403_0444);
    wait_idle();
    chk32("R3", rd_data, 32'h0403_0444);
    chk_period("R3", 30.0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    t_reset();
    t_switch_path1();
    t_live_lock();
    t_dyn_enable();
    t_switch_path0();
    t_pll();
    t_odd_divide();
    t_ref3();
    chk32("R9", glitches, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule